// File: doc/BRIEF.md
# Iterative-Deepening Traversal Root Controller

This block sits at the root of a network of traversal nodes. Each neighbour of the root has its own port. The controller finds out how many nodes the network reaches from the root, and how far away the farthest one is. It does this in a series of rounds. In each round the root sends a request carrying a hop limit to all neighbours in the same cycle. It then waits until every neighbour has answered with an acknowledgement. Each acknowledgement carries the number of newly discovered nodes that the neighbour collected from its part of the network.

The first round uses a hop limit of zero, and each later round raises the limit by one. The root counts itself as discovered before the first round, and adds every round's collected count to a running total. The controller stops after a round that reports no new nodes, or after the round with the largest hop limit it can encode. It then pulses a done flag and holds the total and the hop limit of the last round until the next start.

Top module: `trav_root_ctrl`

## Requirements
- R1: A start pulse while idle begins a round: in the next cycle every bit of `req_vld_o` is high for exactly one cycle, and the first round presents hop limit 0 on `req_hop_o`.
- R2: A round is complete only once an acknowledgement has been accepted from every neighbour. A second acknowledgement from the same neighbour in the same round is ignored, both its count and its completion effect.
- R3: Each round after the first presents a hop limit exactly one greater than the round before.
- R4: `total_o` equals one plus the sum of the counts of all accepted acknowledgements since the start. Each neighbour's count sits at bits [k*CW +: CW] of `ack_cnt_i`.
- R5: After a round whose accepted counts sum to zero, no further round starts. `done_o` is high for one cycle, two cycles after the final acknowledgement is sampled, and `hop_o` holds that round's hop limit. Both `total_o` and `hop_o` keep their values afterwards.
- R6: The round with hop limit 2^HW-1 is always the last one. Its count is added to the total and done follows even when that count is non-zero.
- R7: An accepted start sets `total_o` to 1 and `hop_o` to 0 in the cycle the first request is shown.
- R8: A start pulse while rounds are in progress has no effect on the hop limit, the total or the round sequence.
- R9: Acknowledgements that arrive while the controller is idle are ignored.
- R10: With the default saturating option, `total_o` stops at 2^TW-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a traversal; accepted only while idle |
| req_vld_o | output | NB | One request strobe per neighbour |
| req_hop_o | output | HW | Hop limit carried by the current requests |
| ack_vld_i | input | NB | One acknowledgement strobe per neighbour |
| ack_cnt_i | input | NB*CW | Newly discovered node count, one field per neighbour |
| done_o | output | 1 | One-cycle pulse when traversal ends |
| total_o | output | TW | Discovered node count, including the root |
| hop_o | output | HW | Hop limit of the current or final round |

## Verification
The assertions assume that neighbours answer only after they have seen a request. They also assume that every acknowledgement strobe in a round comes after that round's request, and that no neighbour answers in the cycle the request is shown. The bench models the neighbours to match. It drives acknowledgements only from the cycle after the request strobe, never during it, and never after the final acknowledgement of a round. The only exceptions are deliberate stray acknowledgements while idle and deliberate duplicates within a round. Those exceptions check the ignore rules of R2 and R9, and neither one breaks the one-request, all-acknowledge ordering that the properties rely on.

// File: rtl/trav_pkg.sv
package trav_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2,
      ST_EVAL = 2'd3
   } trav_state_t;

endpackage

// File: rtl/trav_sat_acc.sv
// Accumulator with load; the generate picks saturating or wrapping addition.
module trav_sat_acc #(
   parameter int IW  = 8,
   parameter int TW  = 8,
   parameter bit SAT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] load_val_i,
   input  logic          add_i,
   input  logic [IW-1:0] add_val_i,
   output logic [TW-1:0] val_o
);
   localparam int EW = ((TW > IW) ? TW : IW) + 1;

   logic [TW-1:0] acc_q;
   logic [TW-1:0] nxt;
   logic [EW-1:0] ext;

   assign ext = EW'(acc_q) + EW'(add_val_i);

   generate
      if (SAT) begin : g_sat
         assign nxt = (ext > EW'({TW{1'b1}})) ? {TW{1'b1}} : ext[TW-1:0];
      end else begin : g_wrap
         assign nxt = ext[TW-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (load_i) acc_q <= load_val_i;
      else if (add_i)  acc_q <= nxt;
   end

   assign val_o = acc_q;
endmodule

// File: rtl/trav_ack_collect.sv
// Tracks which neighbours have answered this round and sums fresh counts.
module trav_ack_collect #(
   parameter int NB = 4,
   parameter int CW = 8,
   parameter int SW = CW + $clog2(NB + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             enable_i,
   input  logic [NB-1:0]    ack_vld_i,
   input  logic [NB*CW-1:0] ack_cnt_i,
   output logic             all_o,
   output logic [SW-1:0]    sum_o
);
   logic [NB-1:0] got_q;
   logic [NB-1:0] take;

   generate
      for (genvar k = 0; k < NB; k++) begin : g_port
         assign take[k] = enable_i & ack_vld_i[k] & ~got_q[k];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       got_q <= '0;
      else if (clear_i) got_q <= '0;
      else              got_q <= got_q | take;
   end

   assign all_o = enable_i & (&(got_q | take));

   always_comb begin
      sum_o = '0;
      for (int k = 0; k < NB; k++) begin
         if (take[k]) sum_o = sum_o + SW'(ack_cnt_i[k*CW +: CW]);
      end
   end
endmodule

// File: rtl/trav_round_fsm.sv
// Round sequencer: send, wait for all answers, evaluate, deepen or stop.
module trav_round_fsm
   import trav_pkg::*;
#(
   parameter int HW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          all_i,
   input  logic          zero_i,
   output trav_state_t   state_o,
   output logic [HW-1:0] hop_o,
   output logic          done_o
);
   localparam logic [HW-1:0] HOP_MAX = {HW{1'b1}};

   trav_state_t   st_q;
   logic [HW-1:0] hop_q;
   logic          done_q;
   logic          stop;

   assign stop = zero_i || (hop_q == HOP_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         hop_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               st_q  <= ST_SEND;
               hop_q <= '0;
            end
            ST_SEND: st_q <= ST_WAIT;
            ST_WAIT: if (all_i) st_q <= ST_EVAL;
            ST_EVAL: begin
               if (stop) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  st_q  <= ST_SEND;
                  hop_q <= hop_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o = st_q;
   assign hop_o   = hop_q;
   assign done_o  = done_q;
endmodule

// File: rtl/trav_root_ctrl.sv
module trav_root_ctrl
   import trav_pkg::*;
#(
   parameter int NB        = 4,
   parameter int CW        = 8,
   parameter int HW        = 8,
   parameter int TW        = 16,
   parameter bit TOTAL_SAT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic [NB-1:0]    req_vld_o,
   output logic [HW-1:0]    req_hop_o,
   input  logic [NB-1:0]    ack_vld_i,
   input  logic [NB*CW-1:0] ack_cnt_i,
   output logic             done_o,
   output logic [TW-1:0]    total_o,
   output logic [HW-1:0]    hop_o
);
   localparam int SW = CW + $clog2(NB + 1);

   generate
      if (NB < 1) begin : g_bad_nb
         $error("trav_root_ctrl: NB must be at least 1");
      end
      if (CW < 1 || HW < 1) begin : g_bad_w
         $error("trav_root_ctrl: CW and HW must be at least 1");
      end
      if (TW < 2) begin : g_bad_tw
         $error("trav_root_ctrl: TW must be at least 2");
      end
   endgenerate

   trav_state_t   state;
   logic [HW-1:0] hop;
   logic          all_in;
   logic [SW-1:0] fresh_sum;
   logic [TW-1:0] round_sum;
   logic          in_send, in_wait, in_eval;

   assign in_send = (state == ST_SEND);
   assign in_wait = (state == ST_WAIT);
   assign in_eval = (state == ST_EVAL);

   trav_round_fsm #(.HW(HW)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .all_i   (all_in),
      .zero_i  (round_sum == '0),
      .state_o (state),
      .hop_o   (hop),
      .done_o  (done_o)
   );

   trav_ack_collect #(.NB(NB), .CW(CW), .SW(SW)) u_col (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (in_send),
      .enable_i  (in_wait),
      .ack_vld_i (ack_vld_i),
      .ack_cnt_i (ack_cnt_i),
      .all_o     (all_in),
      .sum_o     (fresh_sum)
   );

   trav_sat_acc #(.IW(SW), .TW(TW), .SAT(1'b1)) u_round (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (in_send),
      .load_val_i ('0),
      .add_i      (in_wait),
      .add_val_i  (fresh_sum),
      .val_o      (round_sum)
   );

   trav_sat_acc #(.IW(TW), .TW(TW), .SAT(TOTAL_SAT)) u_total (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     ((state == ST_IDLE) && start_i),
      .load_val_i (TW'(1)),
      .add_i      (in_eval),
      .add_val_i  (round_sum),
      .val_o      (total_o)
   );

   assign req_vld_o = {NB{in_send}};
   assign req_hop_o = hop;
   assign hop_o     = hop;
endmodule

// File: rtl/trav_root_chk.sv
module trav_root_chk #(
   parameter int NB = 4,
   parameter int HW = 8,
   parameter int TW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic [NB-1:0] req_vld_o,
   input logic [HW-1:0] req_hop_o,
   input logic [NB-1:0] ack_vld_i,
   input logic          done_o,
   input logic [TW-1:0] total_o
);
   logic [NB-1:0] seen_q;
   logic [HW-1:0] prev_hop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q     <= '0;
         prev_hop_q <= '0;
      end else if (|req_vld_o) begin
         seen_q     <= '0;
         prev_hop_q <= req_hop_o;
      end else begin
         seen_q <= seen_q | ack_vld_i;
      end
   end

   // R1
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_vld_o) |=> (req_vld_o == '0));

   // R2
   all_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || ((|req_vld_o) && req_hop_o != '0)) |-> (&seen_q));

   // R3
   hop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|req_vld_o) && req_hop_o != '0) |-> (req_hop_o == HW'(prev_hop_q + 1'b1)));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R4
   total_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (total_o >= $past(total_o)));

   // R4
   done_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (total_o != '0));
endmodule

bind trav_root_ctrl trav_root_chk #(.NB(NB), .HW(HW), .TW(TW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .req_vld_o (req_vld_o),
   .req_hop_o (req_hop_o),
   .ack_vld_i (ack_vld_i),
   .done_o    (done_o),
   .total_o   (total_o)
);

// File: tb/sim_trav_root_ctrl.sv
module sim_trav_root_ctrl;
   localparam int NB   = 3;
   localparam int CW   = 4;
   localparam int HW   = 3;
   localparam int TW   = 8;
   localparam int HMAX = 7;
   localparam int TMAX = 255;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [NB-1:0]    ack_vld = '0;
   logic [NB*CW-1:0] ack_cnt = '0;
   logic [NB-1:0]    req_vld;
   logic [HW-1:0]    req_hop;
   logic             done;
   logic [TW-1:0]    total;
   logic [HW-1:0]    hop;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   trav_root_ctrl #(.NB(NB), .CW(CW), .HW(HW), .TW(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .req_vld_o(req_vld), .req_hop_o(req_hop),
      .ack_vld_i(ack_vld), .ack_cnt_i(ack_cnt),
      .done_o(done), .total_o(total), .hop_o(hop)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int cnt_of(int mode, int z, int k, int h);
      if (h >= z) return 0;
      if (mode == 3) return 15;
      return ((mode * 7 + k * 3 + h * 5 + z) % 15) + ((k == 0) ? 1 : 0);
   endfunction

   task automatic put_ack(input int k, input int v);
      ack_vld[k] = 1'b1;
      ack_cnt[k*CW +: CW] = CW'(v);
   endtask

   task automatic clr_ack();
      ack_vld = '0;
      ack_cnt = '0;
   endtask

   // Quiet window before the final acknowledgement: nothing may advance.
   task automatic hold_check(input int h);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(req_vld == '0 && done == 1'b0, "R2 early round end", int'(req_vld), 0);
         chk(hop == HW'(h), "R8 hop kept during round", int'(hop), h);
      end
   endtask

   task automatic run(input int mode, input int z);
      int  exp_total = 1;
      int  h = 0;
      bit  stop = 1'b0;
      // stray acknowledgements while idle (R9)
      @(negedge clk);
      for (int k = 0; k < NB; k++) put_ack(k, 9);
      @(negedge clk);
      clr_ack();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!stop && h <= HMAX) begin
         int rsum = 0;
         int r;
         chk(req_vld == '1, "R1 request strobes", int'(req_vld), (1 << NB) - 1);
         chk(req_hop == HW'(h), (h == 0) ? "R1 first hop" : "R3 hop step", int'(req_hop), h);
         if (h == 0) begin
            chk(total == 8'd1, "R7 total cleared", int'(total), 1);
            chk(hop == '0, "R7 hop cleared", int'(hop), 0);
         end
         for (int k = 0; k < NB; k++) rsum += cnt_of(mode, z, k, h);
         r = (z + h) % NB;
         if (mode == 0 || mode == 3) begin
            @(negedge clk);
            for (int k = 0; k < NB; k++) put_ack(k, cnt_of(mode, z, k, h));
            @(negedge clk);
            clr_ack();
         end else begin
            for (int i = 0; i < NB; i++) begin
               int k = (mode == 1) ? (r + i) % NB : (NB - 1 - i);
               if (i == NB - 1) begin
                  int kd = (mode == 1) ? r : NB - 1;
                  @(negedge clk);
                  put_ack(kd, 15);             // duplicate, must be ignored (R2)
                  if (mode == 1) start = 1'b1; // start while busy (R8)
                  @(negedge clk);
                  clr_ack();
                  start = 1'b0;
                  hold_check(h);
               end
               for (int g = 0; g < (mode == 1 ? (h + k) % 3 : 0); g++) @(negedge clk);
               @(negedge clk);
               put_ack(k, cnt_of(mode, z, k, h));
               @(negedge clk);
               clr_ack();
            end
         end
         for (int w = 0; w < 8; w++) begin
            if (req_vld != '0 || done) break;
            @(negedge clk);
         end
         exp_total = (exp_total + rsum > TMAX) ? TMAX : exp_total + rsum;
         if (rsum == 0 || h == HMAX) begin
            chk(done == 1'b1, (h == HMAX) ? "R6 stop at hop max" : "R5 stop on empty round", int'(done), 1);
            chk(total == TW'(exp_total), (mode == 3) ? "R10 saturated total" : "R4 total", int'(total), exp_total);
            chk(hop == HW'(h), (h == HMAX) ? "R6 final hop" : "R5 final hop", int'(hop), h);
            @(negedge clk);
            chk(done == 1'b0 && req_vld == '0, "R5 single done pulse", int'(done), 0);
            chk(total == TW'(exp_total), "R5 total held", int'(total), exp_total);
            stop = 1'b1;
         end else begin
            chk(done == 1'b0, "R5 no early done", int'(done), 0);
            h++;
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      chk(req_vld == '0 && done == 1'b0, "R1 reset idle", int'(req_vld), 0);
      chk(total == '0 && hop == '0, "R7 reset values", int'(total), 0);
      rst_n = 1'b1;
      for (int mode = 0; mode < 3; mode++)
         for (int z = 0; z <= HMAX + 1; z++)
            run(mode, z);
      run(3, HMAX + 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule